// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers seven line-interface events into one 8-bit status word. Each event latches its own flag, and the flag holds until software clears it by writing a 0 to that bit position. A per-flag mask and a global enable together decide whether a set flag pulls the single active-low interrupt line low.

The block contains the small detectors that produce the events. A ring detector sees the start of a ring pulse, and can also see the end of the pulse when a mode bit selects both edges. A polarity detector watches the sign bit of the line-voltage field. A saturation detector compares the loop-current field with all ones. Loss of frame lock, receive overload, billing tone and supply dropout arrive as ready-made inputs.

Software uses a small synchronous write port and a combinational read port. The map is: address 0 is the status word, address 1 is the mask, and address 2 is control, with bit 0 as the global enable and bit 1 selecting ring both-edge mode. Address 3 reads zero. Clearing the overload flag also clears a separate overload status output that follows the same event.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset the status, mask and control registers all read 0x00, and irq_n is 1.
- R2: A set flag stays at 1 after its source event goes away, until software clears it.
- R3: Writing status clears exactly the flags whose data bit is 0. A 1 in the written data leaves that flag unchanged, so writing 0xFF has no effect.
- R4: irq_n is 0 exactly when some flag and its mask bit are both 1 and control bit 0 (global enable) is 1. Otherwise irq_n is 1.
- R5: Status bit 1 is reserved and always reads 0.
- R6: Ring flag (bit 7) sets on a rising edge of ring_lvl. It also sets on a falling edge only when control bit 1 is 1.
- R7: Polarity flag (bit 0) sets when lvolt[7] changes in either direction.
- R8: Loop-current flag (bit 2) sets when lcur equals all ones (31). A value of 30 does not set it.
- R9: Overload flag (bit 6) and the ovl_stat output both set on rx_ovl. Clearing bit 6 through a status write also clears ovl_stat.
- R10: Frame flag (bit 5) sets in any cycle where frame_lock is 0.
- R11: If an event arrives in the same cycle as a write that clears its flag, the flag ends at 1.
- R12: billing_tone sets bit 4, and supply_drop sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ring_lvl | input | 1 | Ring pulse level |
| rx_ovl | input | 1 | Receive overload event |
| frame_lock | input | 1 | 1 while the link holds frame lock |
| billing_tone | input | 1 | Billing tone event |
| supply_drop | input | 1 | Line-side supply dropout event |
| lcur | input | 5 | Loop-current field |
| lvolt | input | 8 | Line-voltage field, bit 7 is the sign |
| ovl_stat | output | 1 | Receive-overload status bit |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
On every cycle the assertions check these properties: flags stay sticky unless cleared, an event always beats a clearing write, the reserved bit stays at zero, a falling ring edge is ignored in start-only mode, saturation sets its flag, the overload status drops when its flag is cleared, and a disabled global enable keeps the interrupt high. Some behaviours can only be shown by the bench's scenarios. These are the exact status values seen through the read port, that writing ones has no effect, that either polarity direction sets the flag, that a value one below all ones does not set the saturation flag, and the full mask-and-enable truth table that drives the interrupt.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NFLAG  = 8;
  localparam int ADDR_W = 2;
  localparam int B_RING  = 7;
  localparam int B_OVL   = 6;
  localparam int B_FRAME = 5;
  localparam int B_BILL  = 4;
  localparam int B_DROP  = 3;
  localparam int B_SAT   = 2;
  localparam int B_RSVD  = 1;
  localparam int B_POL   = 0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam int C_GIE  = 0;
  localparam int C_BOTH = 1;

  // Interrupt line level from flags, mask and global enable
  function automatic logic irq_level_n(input logic [NFLAG-1:0] fl,
                                       input logic [NFLAG-1:0] mk,
                                       input logic gie);
    return !(gie && (|(fl & mk)));
  endfunction
endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
  parameter int LCUR_W  = 5,
  parameter int LVOLT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ring_lvl,
  input  logic               ring_both,
  input  logic [LVOLT_W-1:0] lvolt,
  input  logic [LCUR_W-1:0]  lcur,
  output logic               ring_evt,
  output logic               pol_evt,
  output logic               sat_evt
);
  localparam int SIGN_B = LVOLT_W - 1;

  function automatic logic is_full(input logic [LCUR_W-1:0] v);
    return &v;
  endfunction

  // history registers; primed blocks events in the first cycle after reset
  logic primed, ring_q, sign_q;
  logic ring_rise, ring_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      ring_q <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      primed <= 1'b1;
      ring_q <= ring_lvl;
      sign_q <= lvolt[SIGN_B];
    end
  end

  assign ring_rise = primed &&  ring_lvl && !ring_q;
  assign ring_fall = primed && !ring_lvl &&  ring_q;
  assign ring_evt  = ring_rise || (ring_both && ring_fall);
  assign pol_evt   = primed && (lvolt[SIGN_B] != sign_q);
  assign sat_evt   = is_full(lcur);

  AST_RING_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_both && ring_fall) |-> !ring_evt); // R6
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == B_RSVD) begin : g_rsvd
      assign flags[i] = 1'b0;
    end else begin : g_live
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          f_q <= 1'b0;
        else if (set_vec[i]) f_q <= 1'b1;
        else if (clr_vec[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !clr_vec[i]) |=> flags[i]); // R2
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> flags[i]); // R11
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[B_RSVD]); // R5
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int LCUR_W  = 5,
  parameter int LVOLT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NFLAG-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [NFLAG-1:0]   rd_data,
  input  logic               ring_lvl,
  input  logic               rx_ovl,
  input  logic               frame_lock,
  input  logic               billing_tone,
  input  logic               supply_drop,
  input  logic [LCUR_W-1:0]  lcur,
  input  logic [LVOLT_W-1:0] lvolt,
  output logic               ovl_stat,
  output logic               irq_n
);
  logic [NFLAG-1:0] mask_q, ctrl_q, flags, set_vec, clr_vec;
  logic ring_evt, pol_evt, sat_evt;
  logic gie, ovl_q;

  irq_evt_detect #(.LCUR_W(LCUR_W), .LVOLT_W(LVOLT_W)) u_det (
    .clk(clk), .rst_n(rst_n), .ring_lvl(ring_lvl), .ring_both(ctrl_q[C_BOTH]),
    .lvolt(lvolt), .lcur(lcur),
    .ring_evt(ring_evt), .pol_evt(pol_evt), .sat_evt(sat_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_RING]  = ring_evt;
    set_vec[B_OVL]   = rx_ovl;
    set_vec[B_FRAME] = !frame_lock;
    set_vec[B_BILL]  = billing_tone;
    set_vec[B_DROP]  = supply_drop;
    set_vec[B_SAT]   = sat_evt;
    set_vec[B_POL]   = pol_evt;
  end

  assign clr_vec = (wr_en && wr_addr == A_STAT) ? ~wr_data : '0;

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      ovl_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data & 8'h03;
      if (rx_ovl)              ovl_q <= 1'b1;
      else if (clr_vec[B_OVL]) ovl_q <= 1'b0;
    end
  end

  assign gie      = ctrl_q[C_GIE];
  assign ovl_stat = ovl_q;
  assign irq_n    = irq_level_n(flags, mask_q, gie);

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = flags;
      A_MASK:  rd_data = mask_q;
      A_CTRL:  rd_data = ctrl_q;
      default: rd_data = '0;
    endcase
  end

  AST_GIE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq_n); // R4
  AST_NO_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> irq_n); // R4
  AST_SAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (&lcur) |=> flags[B_SAT]); // R8
  AST_OVL_LINKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[B_OVL] && !rx_ovl) |=> !ovl_stat); // R9
endmodule

// File: tb/irq_stat_ctrl_tb.sv
`timescale 1ns/1ps
module irq_stat_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic ring_lvl = 0, rx_ovl = 0, frame_lock = 1, billing_tone = 0, supply_drop = 0;
  logic [4:0] lcur = '0;
  logic [7:0] lvolt = '0;
  logic ovl_stat, irq_n;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_stat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ring_lvl(ring_lvl), .rx_ovl(rx_ovl),
    .frame_lock(frame_lock), .billing_tone(billing_tone), .supply_drop(supply_drop),
    .lcur(lcur), .lvolt(lvolt), .ovl_stat(ovl_stat), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic t_reset();
    rd("R1", 2'd0, 8'h00); rd("R1", 2'd1, 8'h00); rd("R1", 2'd2, 8'h00);
    chk("R1", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_frame();
    frame_lock = 0; step(); frame_lock = 1;
    rd("R10", 2'd0, 8'h20);
    step(); step();
    rd("R2", 2'd0, 8'h20);
    wr(2'd0, 8'hFF);
    rd("R3", 2'd0, 8'h20);
    wr(2'd0, 8'hDF);
    rd("R3", 2'd0, 8'h00);
  endtask

  task automatic t_ring();
    ring_lvl = 1; step();
    rd("R6", 2'd0, 8'h80);
    step(); wr(2'd0, 8'h7F);
    ring_lvl = 0; step();
    rd("R6", 2'd0, 8'h00);            // fall ignored in start-only mode
    wr(2'd2, 8'h02);
    ring_lvl = 1; step();
    wr(2'd0, 8'h7F);
    rd("R6", 2'd0, 8'h00);
    ring_lvl = 0; step();
    rd("R6", 2'd0, 8'h80);            // fall seen in both-edge mode
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_pol();
    lvolt = 8'h05; step();
    rd("R7", 2'd0, 8'h00);
    lvolt = 8'h85; step();
    rd("R7", 2'd0, 8'h01);
    wr(2'd0, 8'hFE);
    rd("R7", 2'd0, 8'h00);
    lvolt = 8'h10; step();
    rd("R7", 2'd0, 8'h01);
    wr(2'd0, 8'hFE);
  endtask

  task automatic t_sat();
    lcur = 5'd30; step(); step();
    rd("R8", 2'd0, 8'h00);
    lcur = 5'd31; step(); lcur = 5'd0;
    rd("R8", 2'd0, 8'h04);
    wr(2'd0, 8'hFB);
  endtask

  task automatic t_bill_drop();
    billing_tone = 1; supply_drop = 1; step();
    billing_tone = 0; supply_drop = 0;
    rd("R12", 2'd0, 8'h18);
    wr(2'd0, 8'hFD);                  // try to keep bit 1 written as 0 only
    rd("R5", 2'd0, 8'h18);
    wr(2'd0, 8'h00);
    rd("R3", 2'd0, 8'h00);
  endtask

  task automatic t_ovl();
    rx_ovl = 1; step(); rx_ovl = 0;
    rd("R9", 2'd0, 8'h40);
    chk("R9", {7'd0, ovl_stat}, 8'h01);
    wr(2'd0, 8'hFF);
    chk("R9", {7'd0, ovl_stat}, 8'h01);
    wr(2'd0, 8'hBF);
    rd("R9", 2'd0, 8'h00);
    chk("R9", {7'd0, ovl_stat}, 8'h00);
  endtask

  task automatic t_irq();
    billing_tone = 1; step(); billing_tone = 0;
    chk("R4", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h10);
    chk("R4", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'h01);
    chk("R4", {7'd0, irq_n}, 8'h00);
    wr(2'd1, 8'h08);
    chk("R4", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'hEF);
    chk("R4", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_set_wins();
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'h00; billing_tone = 1;
    step();
    wr_en = 0; billing_tone = 0;
    rd("R11", 2'd0, 8'h10);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step(); step();
    t_reset();
    t_frame();
    t_ring();
    t_pol();
    t_sat();
    t_bill_drop();
    t_ovl();
    t_irq();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule